// File: doc/BRIEF.md
# Result Ring Buffer with Shared-Entry Reuse

This block sits on the result port of a dataflow function unit. Each result the unit produces is pushed into a small circular store. Consumers on the interconnect take results from it later, so most short-lived values never go through the register file. The unit only has to stall when every slot is occupied.

Each stored result carries a sticky share bit, set by the operation that produced it. A transport read of an unshared head entry consumes it. A read of a shared head entry returns the value and leaves it in place, so any number of later transports can use the same result. A release request clears the share bit and removes the head entry in one cycle. A release can come from an explicit transport or from a side effect of a later operation.

The read port is combinational on the head entry. Pushes, pops and releases take effect on the rising clock edge.

Top module: `res_ring_buf`

## Requirements
- R1: While reset is held and in the first cycle after it, `is_empty`=1, `is_full`=0, and `take_vld`=0 even if `take_req` is high.
- R2: A push accepted while the buffer is not full stores `put_data`. Reads return stored values strictly oldest first.
- R3: When the buffer holds DEPTH entries, a push is refused, `put_stall` equals `put_vld`, and the stored contents do not change.
- R4: A read (`take_req`=1, `drop_req`=0) of a non-empty buffer whose head share bit is 0 returns the head with `take_vld`=1 and removes it at the next edge.
- R5: A read of a head whose share bit is 1 returns its data with `take_vld`=1 and `take_shared`=1, and leaves the entry and its position unchanged.
- R6: `drop_req`=1 on a non-empty buffer removes the head whatever its share bit. If `take_req` is also high in that cycle, the head data is returned.
- R7: A read or release on an empty buffer gives `take_vld`=0 and changes no state.
- R8: A push and a removal in the same cycle on a buffer that is not full both take effect, and occupancy is unchanged. On a full buffer the push is refused even when a removal happens in the same cycle.
- R9: Positions wrap modulo DEPTH, so FIFO order holds over any number of passes around the store.
- R10: `is_empty` is 1 exactly when 0 entries are held. `is_full` is 1 exactly when DEPTH entries are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| put_vld | input | 1 | Function unit offers a result |
| put_data | input | DATA_W | Result value |
| put_share | input | 1 | Sticky share bit for this result |
| put_stall | output | 1 | Push refused because the buffer is full |
| take_req | input | 1 | Transport read of the head entry |
| drop_req | input | 1 | Release: clear share and remove the head |
| take_vld | output | 1 | Read returned a valid entry |
| take_data | output | DATA_W | Head entry data |
| take_shared | output | 1 | Returned entry is shared (not consumed) |
| is_empty | output | 1 | No entries held |
| is_full | output | 1 | DEPTH entries held |

## Verification
A push can arrive in the same cycle as the head is consumed, peeked or released. The push and the removal must then both take effect, or the push alone must be refused when the buffer is full. The bench reaches this directly: it fills the store, then pushes while reading shared and unshared heads and while releasing. It also runs a long random mix of all four inputs. Every cycle, a queue model decides which of the two operations lands, and the bench compares the flags and the head data against it.

// File: rtl/rrb_pkg.sv
package rrb_pkg;

    // What happens to the head entry in a given cycle
    typedef enum logic [1:0] {
        HD_IDLE = 2'd0,  // nothing touches the head
        HD_PEEK = 2'd1,  // shared head read, kept in place
        HD_TAKE = 2'd2,  // unshared head read, removed
        HD_DROP = 2'd3   // explicit release, removed
    } head_act_e;

    // Increment a slot index modulo n
    function automatic int unsigned wrap_inc(int unsigned p, int unsigned n);
        return (p + 1 >= n) ? 0 : p + 1;
    endfunction

    // Decide the head action from request lines and head share bit
    function automatic head_act_e classify(logic nonempty, logic rd, logic rel, logic sh);
        if (!nonempty) return HD_IDLE;
        if (rel)       return HD_DROP;
        if (rd)        return sh ? HD_PEEK : HD_TAKE;
        return HD_IDLE;
    endfunction

    function automatic logic removes(head_act_e a);
        return (a == HD_TAKE) || (a == HD_DROP);
    endfunction

endpackage

// File: rtl/rrb_store.sv
module rrb_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_share,
    input  logic              clr_en,
    input  logic [PW-1:0]     rd_ptr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_share
);
    typedef struct packed {
        logic              share;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            // a removed head loses its sticky bit
            if (clr_en) mem_q[rd_ptr].share <= 1'b0;
            if (wr_en) begin
                mem_q[wr_ptr].data  <= wr_data;
                mem_q[wr_ptr].share <= wr_share;
            end
        end
    end

    assign rd_data  = mem_q[rd_ptr].data;
    assign rd_share = mem_q[rd_ptr].share;

endmodule

// File: rtl/rrb_ctrl.sv
module rrb_ctrl
    import rrb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_vld,
    input  logic          rd_req,
    input  logic          rel_req,
    input  logic          head_share,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic          accept,
    output logic          pop,
    output logic          stall,
    output logic          rd_ok,
    output logic          empty,
    output logic          full
);
    logic [PW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] count_q;
    head_act_e     act;

    assign empty  = (count_q == '0);
    assign full   = (count_q == CW'(DEPTH));
    assign accept = push_vld & ~full;
    assign stall  = push_vld & full;
    assign act    = classify(~empty, rd_req, rel_req, head_share);
    assign pop    = removes(act);
    assign rd_ok  = rd_req & ~empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (accept) wr_ptr_q <= PW'(wrap_inc(32'(wr_ptr_q), DEPTH));
            if (pop)    rd_ptr_q <= PW'(wrap_inc(32'(rd_ptr_q), DEPTH));
            count_q <= count_q + CW'(accept) - CW'(pop);
        end
    end

    assign wr_ptr = wr_ptr_q;
    assign rd_ptr = rd_ptr_q;

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= CW'(DEPTH));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push_vld && full) |=> (wr_ptr_q == $past(wr_ptr_q)));

    // R5
    share_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act == HD_PEEK) |=> (rd_ptr_q == $past(rd_ptr_q)));

    // R6
    release_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (rel_req && !empty) |=> (rd_ptr_q != $past(rd_ptr_q)));

    // R7
    empty_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && !push_vld) |=> empty);

    // R8
    balance_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && pop) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/res_ring_buf.sv
module res_ring_buf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              put_vld,
    input  logic [DATA_W-1:0] put_data,
    input  logic              put_share,
    output logic              put_stall,
    input  logic              take_req,
    input  logic              drop_req,
    output logic              take_vld,
    output logic [DATA_W-1:0] take_data,
    output logic              take_shared,
    output logic              is_empty,
    output logic              is_full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          accept, pop, rd_ok, head_share;
    logic [DATA_W-1:0] head_data;

    rrb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .push_vld   (put_vld),
        .rd_req     (take_req),
        .rel_req    (drop_req),
        .head_share (head_share),
        .wr_ptr     (wr_ptr),
        .rd_ptr     (rd_ptr),
        .accept     (accept),
        .pop        (pop),
        .stall      (put_stall),
        .rd_ok      (rd_ok),
        .empty      (is_empty),
        .full       (is_full)
    );

    rrb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept),
        .wr_ptr   (wr_ptr),
        .wr_data  (put_data),
        .wr_share (put_share),
        .clr_en   (pop),
        .rd_ptr   (rd_ptr),
        .rd_data  (head_data),
        .rd_share (head_share)
    );

    assign take_vld    = rd_ok;
    assign take_data   = head_data;
    assign take_shared = rd_ok & head_share;

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (is_empty && take_req) |-> !take_vld);

endmodule

// File: tb/sim_res_ring_buf.sv
module sim_res_ring_buf;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic put_vld = 0, put_share = 0, take_req = 0, drop_req = 0;
    logic [DW-1:0] put_data = '0;
    logic put_stall, take_vld, take_shared, is_empty, is_full;
    logic [DW-1:0] take_data;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic          sh;
        logic [DW-1:0] d;
    } ent_t;
    ent_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    res_ring_buf #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .put_vld(put_vld), .put_data(put_data), .put_share(put_share),
        .put_stall(put_stall),
        .take_req(take_req), .drop_req(drop_req),
        .take_vld(take_vld), .take_data(take_data), .take_shared(take_shared),
        .is_empty(is_empty), .is_full(is_full)
    );

    task automatic chk(string tag, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL [%s] %s actual=%0h expected=%0h", tag, req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare, advance the model
    task automatic step(string tag, bit pv, logic [DW-1:0] pd, bit ps, bit rr, bit rl);
        bit ne, full_m, pop, acc;
        @(negedge clk);
        put_vld = pv; put_data = pd; put_share = ps; take_req = rr; drop_req = rl;
        #1;
        ne     = q.size() > 0;
        full_m = q.size() == DEPTH;
        chk(tag, "R10 is_empty", 32'(is_empty), 32'(!ne));
        chk(tag, "R10 is_full",  32'(is_full),  32'(full_m));
        chk(tag, "R3 put_stall", 32'(put_stall), 32'(pv && full_m));
        chk(tag, ne ? "R4 take_vld" : "R7 take_vld", 32'(take_vld), 32'(rr && ne));
        if (rr && ne) begin
            chk(tag, "R2 take_data",   32'(take_data),   32'(q[0].d));
            chk(tag, "R5 take_shared", 32'(take_shared), 32'(q[0].sh));
        end
        pop = ne && (rl || (rr && !q[0].sh));
        acc = pv && !full_m;
        if (pop) void'(q.pop_front());
        if (acc) q.push_back('{sh: ps, d: pd});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: reset state, even with a read request pending
        take_req = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1", "R1 is_empty", 32'(is_empty), 32'd1);
        chk("R1", "R1 is_full",  32'(is_full),  32'd0);
        chk("R1", "R1 take_vld", 32'(take_vld), 32'd0);
        rst = 0;
        take_req = 0;

        // R7: read and release on empty
        step("R7", 0, 0, 0, 1, 0);
        step("R7", 0, 0, 0, 1, 1);
        step("R7", 0, 0, 0, 0, 0);

        // R2 / R10: fill, then R3: push while full
        for (int i = 0; i < DEPTH; i++) step("R2", 1, 16'h100 + 16'(i), 0, 0, 0);
        step("R3", 1, 16'hDEAD, 0, 0, 0);
        step("R3", 1, 16'hBEEF, 1, 0, 0);
        // R8: full push refused while a pop happens
        step("R8", 1, 16'hCAFE, 0, 1, 0);
        // R4: drain in order
        for (int i = 0; i < DEPTH; i++) step("R4", 0, 0, 0, 1, 0);
        step("R7", 0, 0, 0, 1, 0);

        // R5: shared head reused several times, then R6 release with read
        step("R5", 1, 16'h5A5A, 1, 0, 0);
        step("R5", 1, 16'h0077, 0, 1, 0);
        step("R5", 0, 0, 0, 1, 0);
        step("R5", 0, 0, 0, 1, 0);
        step("R6", 0, 0, 0, 1, 1);
        step("R6", 0, 0, 0, 1, 0);
        // R6: release of unshared entry without read
        step("R6", 1, 16'h0042, 0, 0, 0);
        step("R6", 0, 0, 0, 0, 1);
        step("R6", 0, 0, 0, 1, 0);

        // R8: push with shared peek, unshared take, release, on partly full buffer
        step("R8", 1, 16'h0A01, 1, 0, 0);
        step("R8", 1, 16'h0A02, 0, 1, 0);
        step("R8", 1, 16'h0A03, 0, 1, 1);
        step("R8", 1, 16'h0A04, 0, 1, 0);
        step("R8", 1, 16'h0A05, 1, 1, 0);

        // R9: long random mix wraps the pointers many times
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            step("R9", r < 55, 16'($urandom), $urandom_range(0, 3) == 0,
                 $urandom_range(0, 1) == 1, r > 90);
        end
        for (int i = 0; i < DEPTH + 1; i++) step("R9", 0, 0, 0, 1, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule